// File: doc/BRIEF.md
# Indexed Configuration Window with ID Unlock

This block places a two-port window onto a 256-byte configuration space on a local bus. Software writes a register number to the index port, which sits at the window base, and then reads or writes that register through the data port, four bytes higher. The window base is 0x78 or 0x178, chosen by a parameter. A lock strap can guard the window. When the lock is on, the window closes after every data-port access. Software reopens it by writing the instance's own identifier, 0x60 plus a 2-bit instance number, to the index port.

A bus access is 8, 16 or 32 bits wide and starts with a one-cycle strobe. The block breaks each access into single-byte operations and runs them one per cycle, at ascending addresses, lowest byte first. Read bytes are gathered into the matching lanes of the result, and a done pulse marks the end. Registers 0x50 to 0x59 are held inside the block. Any other index is read through a narrow read-only port to a neighbouring register file. A write to register 0x51 sends a one-cycle pulse that tells the address decoder to refresh.

Top module: `cfg_window`

## Requirements
- R1: Reset leaves the window open with the index at 0x00, so an index-port read returns 0x00. Register 0x59 resets to 0x40, and bus_busy is 0 with bus_rdata all ones.
- R2: Register 0x50 reads as follows: bit 7 is the lock strap, bit 6 is 0, bit 5 is 1 for base 0x78 and 0 for base 0x178, bits 4:3 are the instance number, bit 2 is the event flag, and bits 1:0 read 2'b10.
- R3: While the window is open, a write to the index port (base+0) loads the index, and an index-port read returns the current index.
- R4: While the window is closed, index-port and data-port reads return 0xFF. Data-port writes change no register. An index-port write of any value other than the identifier leaves the window closed and the index unchanged.
- R5: While the window is closed and the lock is on, writing the identifier (0x60 + instance number) to the index port opens the window and keeps the index.
- R6: With the lock on, any data-port access (base+4), read or write, closes the window again.
- R7: With the lock off, the window stays open across data-port accesses.
- R8: Data-port writes change only registers 0x51 to 0x59. Registers 0x53 and 0x55 keep only bits 7:6, register 0x57 keeps the bits of mask 0xDC, and the others keep all eight bits. A write to 0x50 is ignored.
- R9: A data-port write to register 0x51 raises decode_upd for exactly one cycle. A write to any other register leaves it low.
- R10: flag_set sets bit 2 of register 0x50, and a data-port read of register 0x50 clears it. If both happen in the same cycle, the bit stays set. The read returns the value from before the clear.
- R11: An access of size code 0 (8 bit), 1 (16 bit) or 2 (32 bit) at address A runs byte operations at A, A+1, and so on, lowest byte first. Byte n is taken from wdata[8n+7:8n], and a read byte goes to rdata[8n+7:8n]. Lanes beyond the size, and all lanes of a write, read 0xFF.
- R12: Port offsets 1, 2, 3, 5, 6 and 7, and addresses outside the window, read 0xFF and ignore writes.
- R13: A data-port read of an index outside 0x50 to 0x59 returns rf_rdata, and rf_idx always shows the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_strap | input | 1 | 1 = window relocks after each data access |
| flag_set | input | 1 | Sets the event flag, bit 2 of register 0x50 |
| bus_stb | input | 1 | One-cycle access strobe; ignored while busy |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit |
| bus_addr | input | 9 | Byte address of lowest lane |
| bus_wdata | input | 32 | Write data, lane n = byte n |
| bus_busy | output | 1 | Byte operations in progress |
| bus_done | output | 1 | One-cycle pulse when an access finishes |
| bus_rdata | output | 32 | Gathered read data, held until the next access |
| rf_idx | output | 8 | Current index, to the external register file |
| rf_rdata | input | 8 | External register file read value |
| decode_upd | output | 1 | One-cycle pulse after a write to register 0x51 |

## Verification
Two functions can meet in a single cycle: the flag being set by flag_set, and the flag being cleared as a side effect of a data-port read of register 0x50. The bench issues that read and raises flag_set exactly in the cycle of its one byte operation. It then judges the outcome by reopening the window and reading register 0x50 again, where bit 2 must still be set. A second read, with no set alongside it, must then show the bit cleared.

// File: rtl/cfgw_pkg.sv
// Package cfgw_pkg
// Shared types and constant functions for the configuration window.
// Assumes an 8-bit register index space and a 9-bit byte address.
package cfgw_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic       vld;
        logic       we;
        logic [8:0] addr;
        logic [7:0] wdata;
    } byte_op_t;

    // Which bits of an internal register a data-port write may change.
    function automatic logic [7:0] wr_mask(input logic [7:0] a);
        case (a)
            8'h53, 8'h55: wr_mask = 8'hC0;
            8'h57:        wr_mask = 8'hDC;
            default:      wr_mask = 8'hFF;
        endcase
    endfunction

    // Reset value of an internal register.
    function automatic logic [7:0] rst_val(input logic [7:0] a);
        rst_val = (a == 8'h59) ? 8'h40 : 8'h00;
    endfunction

endpackage

// File: rtl/cfgw_lane_seq.sv
// Module cfgw_lane_seq
// Turns one bus access (8/16/32 bit) into single-byte operations, one per
// cycle, at ascending addresses. Gathers the read bytes into their lanes.
// Assumes the strobe lasts one cycle; strobes while busy are dropped.
module cfgw_lane_seq
    import cfgw_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic            we,
    input  logic [1:0]      size,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [7:0]      rd_byte,
    output byte_op_t        op,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rdata
);
    localparam int NL = DW / 8;
    localparam int SW = $clog2(NL);

    logic          lat_we;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [SW-1:0] last;
    logic [SW-1:0] step;
    logic [DW-1:0] acc;
    logic [DW-1:0] acc_nxt;
    logic [SW-1:0] size_last;

    // Index of the final byte for the requested size.
    always_comb begin
        case (size)
            SZ_8:    size_last = SW'(0);
            SZ_16:   size_last = SW'(1);
            default: size_last = SW'(NL - 1);
        endcase
    end

    // Present the current byte operation.
    always_comb begin
        op.vld   = busy;
        op.we    = lat_we;
        op.addr  = lat_addr + AW'(step);
        op.wdata = lat_wdata[{step, 3'b000} +: 8];
    end

    // Merge the byte read this cycle into its lane.
    always_comb begin
        acc_nxt = acc;
        if (!lat_we) acc_nxt[{step, 3'b000} +: 8] = rd_byte;
    end

    // Accept an access, step through the bytes, report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            rdata     <= '1;
            acc       <= '1;
            step      <= '0;
            last      <= '0;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && stb) begin
                busy      <= 1'b1;
                step      <= '0;
                last      <= size_last;
                lat_we    <= we;
                lat_addr  <= addr;
                lat_wdata <= wdata;
                acc       <= '1;
            end else if (busy) begin
                acc  <= acc_nxt;
                step <= step + SW'(1);
                if (step == last) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    rdata <= acc_nxt;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

endmodule

// File: rtl/cfgw_port_ctl.sv
// Module cfgw_port_ctl
// Decodes a byte operation against the index and data ports and keeps the
// index and the open/closed state of the window.
// Assumes one byte operation per cycle from cfgw_lane_seq.
module cfgw_port_ctl
    import cfgw_pkg::*;
#(
    parameter bit       BASE_HI = 1'b0,
    parameter bit [1:0] INST_ID = 2'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  byte_op_t   op,
    input  logic       lock,
    input  logic [7:0] reg_rdata,
    output logic [7:0] rd_byte,
    output logic [7:0] idx,
    output logic       data_wr,
    output logic       data_rd
);
    localparam logic [8:0] BASE   = BASE_HI ? 9'h178 : 9'h078;
    localparam logic [5:0] BASE_T = BASE[8:3];
    localparam logic [7:0] DEV_ID = 8'h60 | {6'd0, INST_ID};

    logic win_open;
    logic hit, is_idx, is_dat, dat_acc;

    // Port hit decode for the current byte.
    always_comb begin
        hit     = op.vld && (op.addr[8:3] == BASE_T);
        is_idx  = hit && (op.addr[2:0] == 3'd0);
        is_dat  = hit && (op.addr[2:0] == 3'd4);
        dat_acc = is_dat && win_open;
        data_wr = dat_acc && op.we;
        data_rd = dat_acc && !op.we;
    end

    // Read byte returned for the current operation.
    always_comb begin
        if (is_idx)       rd_byte = win_open ? idx : 8'hFF;
        else if (dat_acc) rd_byte = reg_rdata;
        else              rd_byte = 8'hFF;
    end

    // Index load, identifier unlock and relock after a data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b1;
            idx      <= 8'h00;
        end else begin
            if (is_idx && op.we) begin
                if (win_open)                      idx      <= op.wdata;
                else if (lock && op.wdata == DEV_ID) win_open <= 1'b1;
            end
            if (dat_acc && lock) win_open <= 1'b0;
        end
    end

    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && lock) |=> !win_open); // R6
    AST_NOLOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !lock) |=> win_open); // R7
    AST_BAD_ID_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && is_idx && op.we && op.wdata != DEV_ID) |=> (!win_open && $stable(idx))); // R4
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_idx, is_dat})); // R12

endmodule

// File: rtl/cfgw_regs.sv
// Module cfgw_regs
// Holds registers 0x50..0x59: a composed status register at 0x50 and a
// bank of masked writable registers, and forwards other reads to an
// external register file. Assumes data_wr/data_rd last one cycle each.
module cfgw_regs
    import cfgw_pkg::*;
#(
    parameter bit       BASE_HI = 1'b0,
    parameter bit [1:0] INST_ID = 2'd0,
    parameter int       NREG    = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] idx,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    input  logic       lock,
    input  logic       flag_set,
    input  logic [7:0] rf_rdata,
    output logic [7:0] rdata,
    output logic       decode_upd
);
    localparam logic [7:0] STAT_IDX  = 8'h50;
    localparam logic [7:0] FIRST_IDX = 8'h51;
    localparam logic [7:0] LAST_IDX  = FIRST_IDX + 8'(NREG - 1);
    localparam logic [7:0] UPD_IDX   = 8'h51;

    logic [NREG-1:0][7:0] bank;
    logic                 flag;
    logic                 in_bank;
    logic [7:0]           off;
    logic [7:0]           stat;

    // Writable bank, one register per generated block.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] ADDR = FIRST_IDX + 8'(g);
        localparam logic [7:0] MASK = wr_mask(ADDR);
        logic [7:0] q;
        // Masked write of this register.
        always_ff @(posedge clk) begin
            if (!rst_n)                        q <= rst_val(ADDR);
            else if (data_wr && idx == ADDR)   q <= wdata & MASK;
        end
        assign bank[g] = q;
        AST_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            (data_wr && idx == ADDR) |=> ((q & ~MASK) == 8'h00)); // R8
    end

    // Event flag: set wins over the read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (flag_set)                       flag <= 1'b1;
        else if (data_rd && idx == STAT_IDX)     flag <= 1'b0;
    end

    // Decoder refresh pulse after a write to its control register.
    always_ff @(posedge clk) begin
        if (!rst_n) decode_upd <= 1'b0;
        else        decode_upd <= data_wr && (idx == UPD_IDX);
    end

    // Read mux over status, bank and external file.
    always_comb begin
        stat    = {lock, 1'b0, ~BASE_HI, INST_ID, flag, 2'b10};
        in_bank = (idx >= FIRST_IDX) && (idx <= LAST_IDX);
        off     = idx - FIRST_IDX;
        if (idx == STAT_IDX) rdata = stat;
        else if (in_bank)    rdata = bank[off[3:0]];
        else                 rdata = rf_rdata;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag); // R10
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && idx == STAT_IDX && !flag_set) |=> !flag); // R10
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        decode_upd |=> !decode_upd); // R9

endmodule

// File: rtl/cfg_window.sv
// Module cfg_window
// Top of the indexed configuration window: lane sequencer, port control
// and register holder. Assumes a single-cycle bus strobe and polls of
// bus_done for completion.
module cfg_window
    import cfgw_pkg::*;
#(
    parameter bit       BASE_HI = 1'b0,
    parameter bit [1:0] INST_ID = 2'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_strap,
    input  logic        flag_set,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [8:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_busy,
    output logic        bus_done,
    output logic [31:0] bus_rdata,
    output logic [7:0]  rf_idx,
    input  logic [7:0]  rf_rdata,
    output logic        decode_upd
);
    byte_op_t   op;
    logic [7:0] rd_byte;
    logic [7:0] reg_rdata;
    logic       data_wr, data_rd;

    cfgw_lane_seq #(.AW(9), .DW(32)) u_seq (
        .clk(clk), .rst_n(rst_n), .stb(bus_stb), .we(bus_we),
        .size(bus_size), .addr(bus_addr), .wdata(bus_wdata),
        .rd_byte(rd_byte), .op(op), .busy(bus_busy), .done(bus_done),
        .rdata(bus_rdata)
    );

    cfgw_port_ctl #(.BASE_HI(BASE_HI), .INST_ID(INST_ID)) u_port (
        .clk(clk), .rst_n(rst_n), .op(op), .lock(lock_strap),
        .reg_rdata(reg_rdata), .rd_byte(rd_byte), .idx(rf_idx),
        .data_wr(data_wr), .data_rd(data_rd)
    );

    cfgw_regs #(.BASE_HI(BASE_HI), .INST_ID(INST_ID), .NREG(9)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx(rf_idx), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(op.wdata), .lock(lock_strap),
        .flag_set(flag_set), .rf_rdata(rf_rdata), .rdata(reg_rdata),
        .decode_upd(decode_upd)
    );

endmodule

// File: tb/cfg_window_bench.sv
module cfg_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_strap = 1'b1;
    logic        flag_set = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [8:0]  bus_addr = 9'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        bus_busy, bus_done, decode_upd;
    logic [31:0] bus_rdata;
    logic [7:0]  rf_idx, rf_rdata;

    int n_run = 0;
    int n_fail = 0;
    int upd_cnt = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;
    assign rf_rdata = rf_idx ^ 8'h3C;

    cfg_window #(.BASE_HI(1'b0), .INST_ID(2'd1)) u_cfg_window (
        .clk(clk), .rst_n(rst_n), .lock_strap(lock_strap), .flag_set(flag_set),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_busy(bus_busy),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .rf_idx(rf_idx),
        .rf_rdata(rf_rdata), .decode_upd(decode_upd)
    );

    always @(negedge clk) if (decode_upd) upd_cnt++;

    // row: size, we, addr, wdata, expected rdata, requirement number
    localparam int NV = 21;
    localparam logic [83:0] VEC [NV] = '{
        {2'd0, 1'b1, 9'h078, 32'h00000053, 32'hFFFFFFFF, 8'd3},  // R3 load index
        {2'd0, 1'b0, 9'h078, 32'h0,        32'hFFFFFF53, 8'd3},  // R3 read index
        {2'd0, 1'b1, 9'h07C, 32'h000000FF, 32'hFFFFFFFF, 8'd8},  // R8 0x53 masked, R6 closes
        {2'd0, 1'b0, 9'h078, 32'h0,        32'hFFFFFFFF, 8'd4},  // R4 closed index read
        {2'd0, 1'b1, 9'h078, 32'h00000060, 32'hFFFFFFFF, 8'd4},  // R4 wrong id
        {2'd0, 1'b0, 9'h078, 32'h0,        32'hFFFFFFFF, 8'd4},  // R4 still closed
        {2'd0, 1'b1, 9'h078, 32'h00000061, 32'hFFFFFFFF, 8'd5},  // R5 unlock
        {2'd0, 1'b0, 9'h078, 32'h0,        32'hFFFFFF53, 8'd5},  // R5 index kept
        {2'd0, 1'b0, 9'h07C, 32'h0,        32'hFFFFFFC0, 8'd8},  // R8 mask C0, R6 closes
        {2'd0, 1'b0, 9'h07C, 32'h0,        32'hFFFFFFFF, 8'd6},  // R6 closed data read
        {2'd2, 1'b1, 9'h078, 32'h00000061, 32'hFFFFFFFF, 8'd11}, // R11 wide unlock
        {2'd2, 1'b1, 9'h078, 32'hAAAAAA57, 32'hFFFFFFFF, 8'd11}, // R11 low byte to index
        {2'd1, 1'b1, 9'h07B, 32'h0000FF12, 32'hFFFFFFFF, 8'd11}, // R11 byte1 to data
        {2'd0, 1'b1, 9'h078, 32'h00000061, 32'hFFFFFFFF, 8'd5},  // R5
        {2'd0, 1'b1, 9'h078, 32'h00000057, 32'hFFFFFFFF, 8'd3},  // R3
        {2'd1, 1'b0, 9'h07B, 32'h0,        32'hFFFFDCFF, 8'd11}, // R11 lanes, R8 mask DC
        {2'd0, 1'b1, 9'h078, 32'h00000061, 32'hFFFFFFFF, 8'd5},  // R5
        {2'd0, 1'b1, 9'h078, 32'h00000059, 32'hFFFFFFFF, 8'd3},  // R3
        {2'd0, 1'b0, 9'h07C, 32'h0,        32'hFFFFFF40, 8'd1},  // R1 reset value 0x59
        {2'd0, 1'b1, 9'h07A, 32'h00000061, 32'hFFFFFFFF, 8'd12}, // R12 id at hole ignored
        {2'd0, 1'b0, 9'h078, 32'h0,        32'hFFFFFFFF, 8'd12}  // R12 still closed
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic [1:0] sz, input logic we, input logic [8:0] a,
                       input logic [31:0] wd, input bit pulse_flag,
                       output logic [31:0] r);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_stb = 1'b0;
        if (pulse_flag) flag_set = 1'b1;
        @(negedge clk);
        flag_set = 1'b0;
        for (int t = 0; t < 20 && !bus_done; t++) @(negedge clk);
        r = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wr8(input logic [8:0] a, input logic [7:0] v);
        logic [31:0] r;
        acc(2'd0, 1'b1, a, {24'd0, v}, 1'b0, r);
    endtask

    task automatic rd8(input logic [8:0] a, output logic [31:0] r);
        acc(2'd0, 1'b0, a, 32'd0, 1'b0, r);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int c0;
        do_reset();
        chk("R1 busy after reset", {31'd0, bus_busy}, 32'd0);
        chk("R1 rdata after reset", bus_rdata, 32'hFFFFFFFF);
        rd8(9'h078, rd); chk("R1 index after reset", rd, 32'hFFFFFF00);
        wr8(9'h078, 8'h50);
        rd8(9'h07C, rd); chk("R2 status composition", rd, 32'hFFFFFFAA);

        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [83:0] v;
            logic [31:0] r;
            v = VEC[i];
            acc(v[83:82], v[81], v[80:72], v[71:40], 1'b0, r);
            n_run++;
            if (r !== v[39:8]) begin
                n_fail++;
                $display("FAIL R%0d row %0d: got %08h expected %08h", v[7:0], i, r, v[39:8]);
            end
        end

        rd8(9'h080, rd); chk("R12 outside window", rd, 32'hFFFFFFFF);
        wr8(9'h078, 8'h61); wr8(9'h078, 8'h50); wr8(9'h07C, 8'h00);
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R8 status write ignored", rd, 32'hFFFFFFAA);

        @(negedge clk); flag_set = 1'b1; @(negedge clk); flag_set = 1'b0;
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R10 flag set", rd, 32'hFFFFFFAE);
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R10 flag cleared by read", rd, 32'hFFFFFFAA);
        @(negedge clk); flag_set = 1'b1; @(negedge clk); flag_set = 1'b0;
        wr8(9'h078, 8'h61); acc(2'd0, 1'b0, 9'h07C, 32'd0, 1'b1, rd);
        chk("R10 coincident read value", rd, 32'hFFFFFFAE);
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R10 set wins over clear", rd, 32'hFFFFFFAE);

        wr8(9'h078, 8'h61); wr8(9'h078, 8'h51);
        c0 = upd_cnt; wr8(9'h07C, 8'h5A);
        chk("R9 one pulse on 0x51 write", upd_cnt - c0, 32'd1);
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R8 full write 0x51", rd, 32'hFFFFFF5A);
        wr8(9'h078, 8'h61); wr8(9'h078, 8'h52);
        c0 = upd_cnt; wr8(9'h07C, 8'h11);
        chk("R9 no pulse on 0x52 write", upd_cnt - c0, 32'd0);
        wr8(9'h078, 8'h61); wr8(9'h078, 8'h55); wr8(9'h07C, 8'hFF);
        wr8(9'h078, 8'h61); rd8(9'h07C, rd); chk("R8 mask on 0x55", rd, 32'hFFFFFFC0);

        wr8(9'h078, 8'h61); wr8(9'h078, 8'h10);
        chk("R13 rf_idx shows index", {24'd0, rf_idx}, 32'h10);
        rd8(9'h07C, rd); chk("R13 external read", rd, 32'hFFFFFF2C);

        wr8(9'h078, 8'h61); wr8(9'h078, 8'h59);
        acc(2'd2, 1'b0, 9'h07C, 32'd0, 1'b0, rd); chk("R11 wide data read", rd, 32'hFFFFFF40);

        lock_strap = 1'b0;
        do_reset();
        wr8(9'h078, 8'h50);
        rd8(9'h07C, rd); chk("R7 status unlocked", rd, 32'hFFFFFF2A);
        rd8(9'h07C, rd); chk("R7 stays open", rd, 32'hFFFFFF2A);
        rd8(9'h078, rd); chk("R7 index readable", rd, 32'hFFFFFF50);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule